// File: doc/BRIEF.md
# Staged I/O Delay Register Bank

This block holds the 8-bit delay settings for a two-lane memory interface and its command/address pins. Software writes single entries by register address into a staging copy, and the active values seen by the delay primitives do not move. A write to the commit address copies every staged entry into the active copy on one clock edge, so all delays change together. One cycle later a load pulse tells the primitives to latch the new values.

Every active value goes out as two fields. The coarse field is the upper five bits and selects one of 32 equal steps of a reference period. The fine field is the lower three bits, limited to a legal range of 0 to 4. The bank holds three groups. Each lane has nine input entries: eight data bits, then the strobe. Each lane has ten output entries: eight data bits, then the strobe, then the data mask. A shared group holds 32 command/address entries.

Top module: `iodly_bank`

## Requirements
- R1: While reset is held and after it is released, both the staged and the active copy hold parameter defaults: lane input entries `DFLT_IN`, lane output entries `DFLT_OUT`, command/address entries `DFLT_CA`. `dly_load` is low.
- R2: The address layout is group = `wr_addr[7:5]` and offset = `wr_addr[4:0]`. Groups 0 and 1 are the input entries of lanes 0 and 1: offsets 0-7 are the data bits and offset 8 is the strobe. Groups 2 and 3 are the output entries of lanes 0 and 1: offsets 0-7 are the data bits, 8 is the strobe and 9 is the mask. Group 4 is command/address offsets 0-31: address lines from 0, bank lines at 24-26, and we/ras/cas/cke/odt at 27-31.
- R3: A write to a mapped entry updates only that staged entry. No active output changes until a commit.
- R4: A write with `wr_en` high to group 7 is a commit. The offset and data are ignored. On that clock edge, all staged entries become the active entries.
- R5: Staged entries that are not written keep their value, so a partial update followed by a commit leaves all other active values as they were.
- R6: A write to an unmapped location changes neither the staged nor the active copy. Unmapped locations are offsets 9 and above in groups 0-1, offsets 10 and above in groups 2-3, and all of groups 5 and 6.
- R7: For an active value v, the coarse output is v[7:3]. The fine output is v[2:0], or 4 when v[2:0] is 5, 6 or 7.
- R8: `dly_load` is high for exactly the one cycle after a commit edge, and low otherwise.
- R9: With `wr_en` low, neither the address nor the data has any effect.
- R10: Output packing works by slot, with coarse at bits [slot*5 +: 5] and fine at bits [slot*3 +: 3]. For input entries, slot = lane*9 + offset. For output entries, slot = lane*10 + offset. For command/address entries, slot = offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Group (bits 7:5) and offset (bits 4:0) |
| wr_data | input | 8 | Delay value to stage |
| lane_in_coarse | output | 90 | Active coarse codes, lane input entries |
| lane_in_fine | output | 54 | Active clamped fine codes, lane input entries |
| lane_out_coarse | output | 100 | Active coarse codes, lane output entries |
| lane_out_fine | output | 60 | Active clamped fine codes, lane output entries |
| ca_coarse | output | 160 | Active coarse codes, command/address entries |
| ca_fine | output | 96 | Active clamped fine codes, command/address entries |
| dly_load | output | 1 | One-cycle pulse after a commit |

## Verification
The bench first stages a series of writes and checks after each one that the active outputs are still frozen. A design that passed writes straight through would fail here. The writes include offsets just past the end of each group and whole unused groups. A decoder with off-by-one bounds would corrupt a neighbouring lane or the command/address group. Fine codes 5, 6 and 7 are used, so a missing or wrong clamp shows up at the ports. The bench also checks the load pulse and its width. Commit and entry addresses are driven with `wr_en` low, which catches a decoder that ignores the strobe.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  localparam int DLY_W    = 8;
  localparam int COARSE_W = 5;
  localparam int FINE_W   = 3;
  localparam int FINE_MAX = 4;

  typedef logic [DLY_W-1:0]    dly_t;
  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [FINE_W-1:0]   fine_t;

  function automatic coarse_t dly_coarse(dly_t v);
    return v[DLY_W-1:FINE_W];
  endfunction

  function automatic fine_t dly_fine(dly_t v);
    fine_t raw;
    raw = v[FINE_W-1:0];
    if (int'(raw) > FINE_MAX) return fine_t'(FINE_MAX);
    return raw;
  endfunction
endpackage

// File: rtl/iodly_decode.sv
module iodly_decode #(
  parameter int NUM_LANES = 2,
  parameter int IN_PER    = 9,
  parameter int OUT_PER   = 10,
  parameter int CA_NUM    = 32,
  parameter int ADDR_W    = 8,
  parameter int OFS_W     = 5,
  parameter int ENT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ent_hit,
  output logic [ENT_W-1:0]  ent_idx,
  output logic              commit
);
  localparam int GRP_W    = ADDR_W - OFS_W;
  localparam int IN_TOT   = NUM_LANES * IN_PER;
  localparam int OUT_TOT  = NUM_LANES * OUT_PER;
  localparam int CA_GRP   = 2 * NUM_LANES;
  localparam int COMMIT_G = (1 << GRP_W) - 1;

  int grp;
  int ofs;

  always_comb begin
    grp     = int'(wr_addr[ADDR_W-1:OFS_W]);
    ofs     = int'(wr_addr[OFS_W-1:0]);
    ent_hit = 1'b0;
    ent_idx = '0;
    commit  = 1'b0;
    if (wr_en) begin
      if (grp == COMMIT_G) begin
        commit = 1'b1;
      end else if (grp < NUM_LANES) begin
        if (ofs < IN_PER) begin
          ent_hit = 1'b1;
          ent_idx = ENT_W'(grp * IN_PER + ofs);
        end
      end else if (grp < CA_GRP) begin
        if (ofs < OUT_PER) begin
          ent_hit = 1'b1;
          ent_idx = ENT_W'(IN_TOT + (grp - NUM_LANES) * OUT_PER + ofs);
        end
      end else if (grp == CA_GRP) begin
        if (ofs < CA_NUM) begin
          ent_hit = 1'b1;
          ent_idx = ENT_W'(IN_TOT + OUT_TOT + ofs);
        end
      end
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!commit && !ent_hit));
  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && ent_hit));
endmodule

// File: rtl/iodly_store.sv
module iodly_store #(
  parameter int ENT_NUM = 70,
  parameter int ENT_W   = 7,
  parameter logic [ENT_NUM*8-1:0] DFLT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ent_hit,
  input  logic [ENT_W-1:0]     ent_idx,
  input  logic                 commit,
  input  logic [7:0]           wr_data,
  output logic [ENT_NUM*8-1:0] act_flat,
  output logic                 load_pulse
);
  logic [ENT_NUM*8-1:0] stg_flat;
  logic [ENT_NUM*8-1:0] act_q;
  logic                 load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_flat <= DFLT;
      act_q    <= DFLT;
      load_q   <= 1'b0;
    end else begin
      for (int e = 0; e < ENT_NUM; e++) begin
        if (ent_hit && (ent_idx == ENT_W'(e))) stg_flat[e*8 +: 8] <= wr_data;
      end
      if (commit) act_q <= stg_flat;
      load_q <= commit;
    end
  end

  assign act_flat   = act_q;
  assign load_pulse = load_q;

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_flat));
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_flat == $past(stg_flat)));
  assert_stage_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_hit |=> $stable(stg_flat));
  assert_load_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> load_pulse);
  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> !load_pulse);
endmodule

// File: rtl/iodly_split.sv
module iodly_split
  import iodly_pkg::*;
#(
  parameter int ENT_NUM = 70
) (
  input  logic [ENT_NUM*DLY_W-1:0]    act_flat,
  output logic [ENT_NUM*COARSE_W-1:0] coarse_flat,
  output logic [ENT_NUM*FINE_W-1:0]   fine_flat
);
  for (genvar e = 0; e < ENT_NUM; e++) begin : g_ent
    assign coarse_flat[e*COARSE_W +: COARSE_W] = dly_coarse(act_flat[e*DLY_W +: DLY_W]);
    assign fine_flat[e*FINE_W +: FINE_W]       = dly_fine(act_flat[e*DLY_W +: DLY_W]);
  end
endmodule

// File: rtl/iodly_bank.sv
module iodly_bank
  import iodly_pkg::*;
#(
  parameter int   NUM_LANES = 2,
  parameter int   DATA_BITS = 8,
  parameter int   CA_NUM    = 32,
  parameter int   ADDR_W    = 8,
  parameter int   OFS_W     = 5,
  parameter dly_t DFLT_IN   = 8'h3C,
  parameter dly_t DFLT_OUT  = 8'h47,
  parameter dly_t DFLT_CA   = 8'h22
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [DLY_W-1:0]                      wr_data,
  output logic [NUM_LANES*(DATA_BITS+1)*COARSE_W-1:0] lane_in_coarse,
  output logic [NUM_LANES*(DATA_BITS+1)*FINE_W-1:0]   lane_in_fine,
  output logic [NUM_LANES*(DATA_BITS+2)*COARSE_W-1:0] lane_out_coarse,
  output logic [NUM_LANES*(DATA_BITS+2)*FINE_W-1:0]   lane_out_fine,
  output logic [CA_NUM*COARSE_W-1:0]            ca_coarse,
  output logic [CA_NUM*FINE_W-1:0]              ca_fine,
  output logic                                  dly_load
);
  localparam int IN_PER  = DATA_BITS + 1;
  localparam int OUT_PER = DATA_BITS + 2;
  localparam int IN_TOT  = NUM_LANES * IN_PER;
  localparam int OUT_TOT = NUM_LANES * OUT_PER;
  localparam int ENT_NUM = IN_TOT + OUT_TOT + CA_NUM;
  localparam int ENT_W   = $clog2(ENT_NUM);
  localparam logic [ENT_NUM*DLY_W-1:0] DFLT_VEC =
    {{CA_NUM{DFLT_CA}}, {OUT_TOT{DFLT_OUT}}, {IN_TOT{DFLT_IN}}};

  logic                          ent_hit;
  logic [ENT_W-1:0]              ent_idx;
  logic                          commit;
  logic [ENT_NUM*DLY_W-1:0]      act_flat;
  logic [ENT_NUM*COARSE_W-1:0]   coarse_flat;
  logic [ENT_NUM*FINE_W-1:0]     fine_flat;

  iodly_decode #(
    .NUM_LANES(NUM_LANES), .IN_PER(IN_PER), .OUT_PER(OUT_PER), .CA_NUM(CA_NUM),
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ENT_W(ENT_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .ent_hit(ent_hit), .ent_idx(ent_idx), .commit(commit)
  );

  iodly_store #(
    .ENT_NUM(ENT_NUM), .ENT_W(ENT_W), .DFLT(DFLT_VEC)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .ent_hit(ent_hit), .ent_idx(ent_idx),
    .commit(commit), .wr_data(wr_data), .act_flat(act_flat), .load_pulse(dly_load)
  );

  iodly_split #(.ENT_NUM(ENT_NUM)) u_split (
    .act_flat(act_flat), .coarse_flat(coarse_flat), .fine_flat(fine_flat)
  );

  assign lane_in_coarse  = coarse_flat[0 +: IN_TOT*COARSE_W];
  assign lane_in_fine    = fine_flat[0 +: IN_TOT*FINE_W];
  assign lane_out_coarse = coarse_flat[IN_TOT*COARSE_W +: OUT_TOT*COARSE_W];
  assign lane_out_fine   = fine_flat[IN_TOT*FINE_W +: OUT_TOT*FINE_W];
  assign ca_coarse       = coarse_flat[(IN_TOT+OUT_TOT)*COARSE_W +: CA_NUM*COARSE_W];
  assign ca_fine         = fine_flat[(IN_TOT+OUT_TOT)*FINE_W +: CA_NUM*FINE_W];

  for (genvar e = 0; e < ENT_NUM; e++) begin : g_chk
    assert_fine_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fine_flat[e*FINE_W +: FINE_W]) <= FINE_MAX);
  end
endmodule

// File: tb/iodly_bank_tb.sv
`timescale 1ns/1ps
module iodly_bank_tb;
  localparam int TOT = 70;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [89:0]  lane_in_coarse;
  logic [53:0]  lane_in_fine;
  logic [99:0]  lane_out_coarse;
  logic [59:0]  lane_out_fine;
  logic [159:0] ca_coarse;
  logic [95:0]  ca_fine;
  logic         dly_load;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] stg [TOT];
  logic [7:0] act [TOT];

  localparam logic [15:0] VEC [12] = '{
    16'h00A5, 16'h083E, 16'h27FF, 16'h0911, 16'h49D7, 16'h6852,
    16'h6A99, 16'h800B, 16'h98C4, 16'h9F7F, 16'hA344, 16'h4360
  };

  iodly_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lane_in_coarse(lane_in_coarse), .lane_in_fine(lane_in_fine),
    .lane_out_coarse(lane_out_coarse), .lane_out_fine(lane_out_fine),
    .ca_coarse(ca_coarse), .ca_fine(ca_fine), .dly_load(dly_load)
  );

  always #4 clk = ~clk;

  function automatic int slot_of(logic [7:0] a);
    int g = int'(a[7:5]);
    int o = int'(a[4:0]);
    if (g < 2 && o < 9) return g * 9 + o;
    if ((g == 2 || g == 3) && o < 10) return 18 + (g - 2) * 10 + o;
    if (g == 4) return 38 + o;
    return -1;
  endfunction

  function automatic logic [7:0] port_val(int s);
    logic [4:0] c;
    logic [2:0] f;
    if (s < 18) begin
      c = lane_in_coarse[s*5 +: 5]; f = lane_in_fine[s*3 +: 3];
    end else if (s < 38) begin
      c = lane_out_coarse[(s-18)*5 +: 5]; f = lane_out_fine[(s-18)*3 +: 3];
    end else begin
      c = ca_coarse[(s-38)*5 +: 5]; f = ca_fine[(s-38)*3 +: 3];
    end
    return {c, f};
  endfunction

  function automatic logic [7:0] exp_val(logic [7:0] v);
    return {v[7:3], (v[2:0] > 3'd4) ? 3'd4 : v[2:0]};
  endfunction

  task automatic check_all(string req);
    int bad = -1;
    for (int s = 0; s < TOT; s++)
      if (bad < 0 && port_val(s) !== exp_val(act[s])) bad = s;
    n_checks++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s slot %0d: actual %h expected %h", req, bad, port_val(bad), exp_val(act[bad]));
    end
  endtask

  task automatic check_bit(string req, logic actual, logic expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, actual, expected);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic en);
    int s;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) begin
      s = slot_of(a);
      if (a[7:5] == 3'd7) for (int i = 0; i < TOT; i++) act[i] = stg[i];
      else if (s >= 0) stg[s] = d;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOT; i++) begin
      stg[i] = (i < 18) ? 8'h3C : (i < 38) ? 8'h47 : 8'h22;
      act[i] = stg[i];
    end
    repeat (3) @(negedge clk);
    check_all("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset released");
    check_bit("R1 load low", dly_load, 1'b0);

    // R2 R3 R6: staged writes including unmapped ones leave active frozen
    for (int k = 0; k < 12; k++) begin
      wr(VEC[k][15:8], VEC[k][7:0], 1'b1);
      check_all("R3 R6 active frozen");
    end
    wr(8'hE0, 8'h00, 1'b1);
    check_bit("R8 load after commit", dly_load, 1'b1);
    check_all("R4 R2 R10 commit applies map");
    @(negedge clk);
    check_bit("R8 load one cycle", dly_load, 1'b0);

    // R7: 0xFF at lane1 input d7 gives coarse 31 fine 4
    n_checks++;
    if (port_val(16) !== 8'hFC) begin
      n_fail++;
      $display("FAIL R7 clamp: actual %h expected fc", port_val(16));
    end

    // R5: partial update of one bank line
    wr(8'h99, 8'h28, 1'b1);
    wr(8'hE5, 8'h77, 1'b1);
    check_all("R5 partial update");

    // R9: strobe low on entry and commit addresses
    wr(8'h81, 8'hF0, 1'b0);
    wr(8'hE0, 8'h00, 1'b0);
    check_bit("R9 no load without strobe", dly_load, 1'b0);
    wr(8'hFF, 8'h12, 1'b1);
    check_all("R9 write with strobe low not staged");

    // R4: commit with no pending writes changes nothing but still pulses
    check_bit("R8 load on empty commit", dly_load, 1'b1);
    wr(8'hE3, 8'hAB, 1'b1);
    check_all("R4 repeated commit");

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < TOT; i++) begin
      stg[i] = (i < 18) ? 8'h3C : (i < 38) ? 8'h47 : 8'h22;
      act[i] = stg[i];
    end
    @(negedge clk);
    check_all("R1 reset restores defaults");
    check_bit("R1 load cleared", dly_load, 1'b0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule